// File: doc/BRIEF.md
# SCSI Unit Serial Number Inquiry Responder

This block answers the one INQUIRY request that asks a mass-storage device for its unit serial number. It takes a six-byte command descriptor block and checks it. If the request is for the serial-number vital-product page, the block scans a 20-byte raw serial string that a drive identify transaction has already placed in a small buffer, one byte per clock. It drops every null and space character and keeps the rest in their original order. It then streams a four-byte page header and the kept characters out over a valid/ready byte interface.

The page length in the header is the number of characters that survive the filter, so a drive that pads its serial field with blanks or nulls reports only its meaningful characters. The response is cut at the allocation length carried in the command. A request for any other page is rejected with an error flag and produces no data. A command with a different operation code, or a plain standard-inquiry request, is accepted and then ignored.

Top module: `sn_inquiry_resp`

## Requirements
- R1: A command is acted on only when descriptor byte 0 (cdb_i[7:0]) is 12h; any other operation code is consumed with no data, no done pulse and no error flag.
- R2: The serial page is served when bit 0 of byte 1 (cdb_i[8]) is 1 and byte 2 (cdb_i[23:16]) is 80h, whatever the other bits of byte 1 hold. Opcode 12h with cdb_i[8]=0 and byte 2 = 00h produces no output and no error.
- R3: Response byte 0 is {qual_i[2:0], dev_type_i[4:0]}, sampled when the command is accepted.
- R4: Response byte 1 is 80h and response byte 2 is 00h.
- R5: Response byte 3 equals the number of raw serial bytes that are neither 00h nor 20h.
- R6: Response bytes 4 onward are the kept raw bytes in buffer order (address 0 first), with every 00h and 20h removed. For example, raw "713 740" gives "713740" and a length of 6.
- R7: The raw buffer is read one address per clock for 20 clocks after acceptance. The first response byte is valid in the 20th cycle after the acceptance edge.
- R8: The number of bytes sent is the smaller of (4 + page length) and the allocation length in byte 4 (cdb_i[39:32]).
- R9: An allocation length of 0 sends no byte, and done_o still pulses.
- R10: Opcode 12h with cdb_i[8]=1 and a page other than 80h, or with cdb_i[8]=0 and a nonzero page, sets illegal_o. No data is sent and done_o does not pulse. The flag stays set until the next accepted command.
- R11: While tx_valid_o is high and tx_ready_i is low, tx_valid_o stays high and tx_data_o keeps its value.
- R12: done_o is high for exactly one cycle, the cycle after the edge that accepts the last byte (or ends the scan when nothing is sent).
- R13: cdb_ready_o is high exactly when the block is idle, and no byte is offered while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cdb_valid_i | input | 1 | Command descriptor present |
| cdb_ready_o | output | 1 | Block idle, command accepted this cycle |
| cdb_i | input | 48 | Descriptor block, byte k at bits 8k+7:8k |
| qual_i | input | 3 | Peripheral qualifier for response byte 0 |
| dev_type_i | input | 5 | Device type code for response byte 0 |
| sn_addr_o | output | 5 | Raw serial buffer read address |
| sn_data_i | input | 8 | Raw serial byte at sn_addr_o (combinational read) |
| tx_valid_o | output | 1 | Response byte valid |
| tx_ready_i | input | 1 | Sink accepts the response byte |
| tx_data_o | output | 8 | Response byte |
| done_o | output | 1 | One-cycle pulse after the response ends |
| illegal_o | output | 1 | Unsupported page requested |

## Verification
The bench uses a serial field with spaces and nulls mixed in, a field with no padding, and a field made only of padding. A filter that missed one of the two pad codes, or that packed characters out of order, would show wrong bytes after the header. The bench sets allocation lengths of 0, 2, 4, exactly 4 plus the page length, and above it. A design that compared against the wrong length would send one byte too many, or it would never raise done when there is nothing to send. Random backpressure tests that a stalled byte is neither dropped nor changed. A sequence of illegal, ignored and good commands tests that the error flag is raised only for wrong page requests and is cleared by the next command.

// File: rtl/sni_pkg.sv
package sni_pkg;
  localparam logic [7:0] OP_INQUIRY = 8'h12;
  localparam logic [7:0] PAGE_SERIAL = 8'h80;
  localparam logic [7:0] PAD_NUL = 8'h00;
  localparam logic [7:0] PAD_SPC = 8'h20;
  localparam int HDR_BYTES = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_SEND = 2'd2,
    ST_DONE = 2'd3
  } resp_state_e;
endpackage

// File: rtl/sni_cdb_decode.sv
module sni_cdb_decode
  import sni_pkg::*;
#(
  parameter int CDB_BYTES = 6,
  parameter int ALLOC_W = 8
) (
  input  logic [8*CDB_BYTES-1:0] cdb_i,
  output logic                   want_sn_o,
  output logic                   bad_page_o,
  output logic [ALLOC_W-1:0]     alloc_o
);
  logic [7:0] opcode, flags, page;
  logic       is_inq, vpd;

  assign opcode = cdb_i[7:0];
  assign flags  = cdb_i[15:8];
  assign page   = cdb_i[23:16];
  assign alloc_o = ALLOC_W'(cdb_i[39:32]);

  assign is_inq = (opcode == OP_INQUIRY);
  assign vpd    = flags[0];

  assign want_sn_o  = is_inq && vpd && (page == PAGE_SERIAL);
  assign bad_page_o = is_inq && ((vpd && page != PAGE_SERIAL) ||
                                 (!vpd && page != 8'h00));

  logic unused_cdb;
  assign unused_cdb = ^{flags[7:1], cdb_i[31:24], cdb_i[8*CDB_BYTES-1:40]};
endmodule

// File: rtl/sni_filter.sv
module sni_filter
  import sni_pkg::*;
#(
  parameter int SN_LEN = 20,
  parameter int IDX_W = $clog2(SN_LEN),
  parameter int CNT_W = $clog2(SN_LEN + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  output logic [IDX_W-1:0]    addr_o,
  input  logic [7:0]          data_i,
  output logic                last_o,
  output logic [CNT_W-1:0]    cnt_o,
  output logic [8*SN_LEN-1:0] kept_o
);
  logic             run_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       kept_q [SN_LEN];
  logic             keep;

  assign keep   = (data_i != PAD_NUL) && (data_i != PAD_SPC);
  assign last_o = run_q && (idx_q == IDX_W'(SN_LEN - 1));
  assign addr_o = idx_q;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      idx_q <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      idx_q <= '0;
      cnt_q <= '0;
    end else if (run_q) begin
      idx_q <= idx_q + IDX_W'(1);
      if (keep) cnt_q <= cnt_q + CNT_W'(1);
      if (last_o) run_q <= 1'b0;
    end
  end

  // compacting store: kept characters land at the running count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SN_LEN; i++) kept_q[i] <= '0;
    end else if (run_q && keep) begin
      kept_q[cnt_q[IDX_W-1:0]] <= data_i;
    end
  end

  for (genvar g = 0; g < SN_LEN; g++) begin : g_flat
    assign kept_o[8*g +: 8] = kept_q[g];
  end
endmodule

// File: rtl/sni_tx_mux.sv
module sni_tx_mux
  import sni_pkg::*;
#(
  parameter int SN_LEN = 20,
  parameter int IDX_W = $clog2(SN_LEN),
  parameter int CNT_W = $clog2(SN_LEN + 1),
  parameter int POS_W = 8
) (
  input  logic [POS_W-1:0]    pos_i,
  input  logic [7:0]          hdr_i,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic [8*SN_LEN-1:0] kept_i,
  output logic [7:0]          data_o
);
  logic [7:0]       kept_arr [SN_LEN];
  logic [POS_W-1:0] off;

  for (genvar g = 0; g < SN_LEN; g++) begin : g_arr
    assign kept_arr[g] = kept_i[8*g +: 8];
  end

  assign off = pos_i - POS_W'(HDR_BYTES);

  always_comb begin
    data_o = 8'h00;
    unique case (pos_i)
      POS_W'(0): data_o = hdr_i;
      POS_W'(1): data_o = PAGE_SERIAL;
      POS_W'(2): data_o = 8'h00;
      POS_W'(3): data_o = 8'(cnt_i);
      default: begin
        if (off < POS_W'(SN_LEN)) data_o = kept_arr[off[IDX_W-1:0]];
      end
    endcase
  end
endmodule

// File: rtl/sn_inquiry_resp.sv
module sn_inquiry_resp
  import sni_pkg::*;
#(
  parameter int SN_LEN = 20,
  parameter int CDB_BYTES = 6,
  parameter int ALLOC_W = 8,
  localparam int IDX_W = $clog2(SN_LEN),
  localparam int CNT_W = $clog2(SN_LEN + 1),
  localparam int CDB_W = 8 * CDB_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cdb_valid_i,
  output logic             cdb_ready_o,
  input  logic [CDB_W-1:0] cdb_i,
  input  logic [2:0]       qual_i,
  input  logic [4:0]       dev_type_i,
  output logic [IDX_W-1:0] sn_addr_o,
  input  logic [7:0]       sn_data_i,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  output logic [7:0]       tx_data_o,
  output logic             done_o,
  output logic             illegal_o
);
  resp_state_e state_q;
  logic [ALLOC_W-1:0] alloc_q, pos_q, full_len, total;
  logic [7:0]         hdr_q;
  logic               illegal_q;
  logic               want_sn, bad_page, accept, start, scan_last;
  logic [ALLOC_W-1:0] alloc_d;
  logic [CNT_W-1:0]   kept_cnt;
  logic [8*SN_LEN-1:0] kept;

  sni_cdb_decode #(.CDB_BYTES(CDB_BYTES), .ALLOC_W(ALLOC_W)) u_dec (
    .cdb_i      (cdb_i),
    .want_sn_o  (want_sn),
    .bad_page_o (bad_page),
    .alloc_o    (alloc_d)
  );

  assign accept = cdb_valid_i && (state_q == ST_IDLE);
  assign start  = accept && want_sn;

  sni_filter #(.SN_LEN(SN_LEN)) u_filt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .addr_o  (sn_addr_o),
    .data_i  (sn_data_i),
    .last_o  (scan_last),
    .cnt_o   (kept_cnt),
    .kept_o  (kept)
  );

  sni_tx_mux #(.SN_LEN(SN_LEN), .POS_W(ALLOC_W)) u_mux (
    .pos_i  (pos_q),
    .hdr_i  (hdr_q),
    .cnt_i  (kept_cnt),
    .kept_i (kept),
    .data_o (tx_data_o)
  );

  assign full_len = ALLOC_W'(kept_cnt) + ALLOC_W'(HDR_BYTES);
  assign total    = (full_len < alloc_q) ? full_len : alloc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      alloc_q   <= '0;
      pos_q     <= '0;
      hdr_q     <= '0;
      illegal_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            illegal_q <= bad_page;
            if (want_sn) begin
              state_q <= ST_SCAN;
              alloc_q <= alloc_d;
              hdr_q   <= {qual_i, dev_type_i};
            end
          end
        end
        ST_SCAN: begin
          pos_q <= '0;
          // total is zero only when the allocation length is zero
          if (scan_last) state_q <= (alloc_q == '0) ? ST_DONE : ST_SEND;
        end
        ST_SEND: begin
          if (tx_ready_i) begin
            pos_q <= pos_q + ALLOC_W'(1);
            if (pos_q == total - ALLOC_W'(1)) state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cdb_ready_o = (state_q == ST_IDLE);
  assign tx_valid_o  = (state_q == ST_SEND);
  assign done_o      = (state_q == ST_DONE);
  assign illegal_o   = illegal_q;
endmodule

// File: rtl/sni_checker.sv
module sni_checker #(
  parameter int SN_LEN = 20
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cdb_valid_i,
  input logic       cdb_ready_o,
  input logic       tx_valid_o,
  input logic       tx_ready_i,
  input logic [7:0] tx_data_o,
  input logic       done_o,
  input logic       illegal_o
);
  logic [7:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else if (cdb_valid_i && cdb_ready_o) idx_q <= '0;
    else if (tx_valid_o && tx_ready_i && idx_q != 8'hff) idx_q <= idx_q + 8'd1;
  end

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R12
  AST_IDLE_NO_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cdb_ready_o |-> !tx_valid_o); // R13
  AST_ILLEGAL_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !tx_valid_o && !done_o); // R10
  AST_PAGE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && idx_q == 8'd1 |-> tx_data_o == 8'h80); // R4
  AST_RESERVED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && idx_q == 8'd2 |-> tx_data_o == 8'h00); // R4
  AST_LEN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && idx_q == 8'd3 |-> tx_data_o <= 8'(SN_LEN)); // R5
  AST_NO_PAD_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && idx_q >= 8'd4 |-> tx_data_o != 8'h00 && tx_data_o != 8'h20); // R6
  AST_LEN_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> idx_q < 8'(SN_LEN + 4)); // R8
endmodule

bind sn_inquiry_resp sni_checker #(.SN_LEN(SN_LEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cdb_valid_i (cdb_valid_i),
  .cdb_ready_o (cdb_ready_o),
  .tx_valid_o  (tx_valid_o),
  .tx_ready_i  (tx_ready_i),
  .tx_data_o   (tx_data_o),
  .done_o      (done_o),
  .illegal_o   (illegal_o)
);

// File: tb/sn_inquiry_resp_test.sv
module sn_inquiry_resp_test;
  localparam int SN_LEN = 20;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        cdb_valid_i;
  logic        cdb_ready_o;
  logic [47:0] cdb_i;
  logic [2:0]  qual_i;
  logic [4:0]  dev_type_i;
  logic [4:0]  sn_addr_o;
  logic [7:0]  sn_data_i;
  logic        tx_valid_o;
  logic        tx_ready_i;
  logic [7:0]  tx_data_o;
  logic        done_o;
  logic        illegal_o;

  logic [7:0] sn_mem [SN_LEN];
  assign sn_data_i = sn_mem[sn_addr_o];

  always #5 clk_i = ~clk_i;

  sn_inquiry_resp uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cdb_valid_i(cdb_valid_i), .cdb_ready_o(cdb_ready_o),
    .cdb_i(cdb_i), .qual_i(qual_i), .dev_type_i(dev_type_i), .sn_addr_o(sn_addr_o),
    .sn_data_i(sn_data_i), .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
    .tx_data_o(tx_data_o), .done_o(done_o), .illegal_o(illegal_o)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit bp_en = 0;
  logic [15:0] lfsr = 16'hace1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // reference model: phase 0 idle, 1 scan, 2 send, 3 done
  int m_phase = 0;
  int m_wait = 0;
  int m_idx = 0;
  int m_rx = 0;
  bit m_ill = 0;
  logic [7:0] exp_q[$];
  logic [7:0] kept_q[$];
  logic [7:0] m_op, m_fl, m_pg, m_al;

  always @(posedge clk_i) begin
    cyc++;
    if (!rst_ni) begin
      m_phase = 0; m_ill = 0; exp_q.delete();
    end else begin
      case (m_phase)
        0: if (cdb_valid_i) begin
          m_op = cdb_i[7:0]; m_fl = cdb_i[15:8]; m_pg = cdb_i[23:16]; m_al = cdb_i[39:32];
          m_ill = (m_op == 8'h12) && ((m_fl[0] && m_pg != 8'h80) || (!m_fl[0] && m_pg != 8'h00));
          m_rx = 0;
          if (m_op == 8'h12 && m_fl[0] && m_pg == 8'h80) begin
            kept_q.delete();
            for (int i = 0; i < SN_LEN; i++)
              if (sn_mem[i] != 8'h00 && sn_mem[i] != 8'h20) kept_q.push_back(sn_mem[i]);
            exp_q.delete();
            exp_q.push_back({qual_i, dev_type_i});
            exp_q.push_back(8'h80);
            exp_q.push_back(8'h00);
            exp_q.push_back(8'(kept_q.size()));
            foreach (kept_q[i]) exp_q.push_back(kept_q[i]);
            while (exp_q.size() > int'(m_al)) void'(exp_q.pop_back());
            m_phase = 1; m_wait = SN_LEN; m_idx = 0;
          end
        end
        1: begin
          m_wait--;
          if (m_wait == 0) m_phase = (exp_q.size() > 0) ? 2 : 3;
        end
        2: if (tx_ready_i) begin
          void'(exp_q.pop_front());
          m_idx++; m_rx++;
          if (exp_q.size() == 0) m_phase = 3;
        end
        default: m_phase = 0;
      endcase
    end
  end

  function automatic string byte_req(input int idx);
    if (idx == 0) return "R3";
    if (idx < 3) return "R4";
    if (idx == 3) return "R5";
    return "R6";
  endfunction

  // per-cycle comparison away from the active edge, then drive tx_ready_i
  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk(cdb_ready_o == (m_phase == 0), "R13", cdb_ready_o, m_phase == 0);
      chk(tx_valid_o == (m_phase == 2), "R7/R8", tx_valid_o, m_phase == 2);
      if (m_phase == 2 && tx_valid_o)
        chk(tx_data_o == exp_q[0], byte_req(m_idx), tx_data_o, exp_q[0]); // R11 under backpressure
      chk(done_o == (m_phase == 3), "R12", done_o, m_phase == 3);
      chk(illegal_o == m_ill, "R10", illegal_o, m_ill);
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready_i = bp_en ? (lfsr[0] | lfsr[5]) & lfsr[9] : 1'b1;
  end

  always @(posedge clk_i) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic set_sn(input string s);
    for (int i = 0; i < SN_LEN; i++) sn_mem[i] = (i < s.len()) ? s[i] : 8'h20;
  endtask

  task automatic run_cmd(input logic [7:0] op, input logic [7:0] fl, input logic [7:0] pg,
                         input logic [7:0] al, input int exp_n, input string req);
    @(negedge clk_i);
    cdb_i = {8'h00, al, 8'h00, pg, fl, op};
    cdb_valid_i = 1'b1;
    @(negedge clk_i);
    cdb_valid_i = 1'b0;
    while (m_phase != 0) @(negedge clk_i);
    @(negedge clk_i);
    chk(m_rx == exp_n, req, m_rx, exp_n);
  endtask

  initial begin
    rst_ni = 1'b0; cdb_valid_i = 1'b0; cdb_i = '0; qual_i = 3'd0; dev_type_i = 5'd0;
    tx_ready_i = 1'b1;
    set_sn("");
    #23;
    chk(cdb_ready_o == 1'b1, "R13", cdb_ready_o, 1);
    chk(tx_valid_o == 1'b0, "R13", tx_valid_o, 0);
    chk(done_o == 1'b0, "R12", done_o, 0);
    chk(illegal_o == 1'b0, "R10", illegal_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R6 worked example, spaces as padding; header fields R3
    qual_i = 3'b010; dev_type_i = 5'h0e;
    set_sn("713 740");
    run_cmd(8'h12, 8'h01, 8'h80, 8'hff, 10, "R8");
    // nulls mixed in, LUN bits set in byte 1 (R2), backpressure (R11)
    set_sn("  7\x00 13  740");
    sn_mem[19] = 8'h00; sn_mem[0] = 8'h00;
    bp_en = 1;
    run_cmd(8'h12, 8'he1, 8'h80, 8'hff, 10, "R2");
    // truncation R8
    run_cmd(8'h12, 8'h01, 8'h80, 8'd2, 2, "R8");
    run_cmd(8'h12, 8'h01, 8'h80, 8'd4, 4, "R8");
    run_cmd(8'h12, 8'h01, 8'h80, 8'd10, 10, "R8");
    // zero allocation R9
    run_cmd(8'h12, 8'h01, 8'h80, 8'd0, 0, "R9");
    // no padding at all, R5 length 20
    qual_i = 3'b000; dev_type_i = 5'h00;
    set_sn("ABCDEFGHIJKLMNOPQRST");
    run_cmd(8'h12, 8'h01, 8'h80, 8'd24, 24, "R5");
    bp_en = 0;
    run_cmd(8'h12, 8'h01, 8'h80, 8'd30, 24, "R8");
    // all padding, length 0
    set_sn("");
    for (int i = 0; i < SN_LEN; i += 3) sn_mem[i] = 8'h00;
    run_cmd(8'h12, 8'h01, 8'h80, 8'hff, 4, "R5");
    // R10 illegal pages
    set_sn("SN42");
    run_cmd(8'h12, 8'h01, 8'h83, 8'hff, 0, "R10");
    chk(illegal_o == 1'b1, "R10", illegal_o, 1);
    run_cmd(8'h12, 8'h00, 8'h80, 8'hff, 0, "R10");
    chk(illegal_o == 1'b1, "R10", illegal_o, 1);
    // R1 other opcode ignored, clears flag
    run_cmd(8'h00, 8'h01, 8'h80, 8'hff, 0, "R1");
    chk(illegal_o == 1'b0, "R1", illegal_o, 0);
    // R2 standard inquiry ignored
    run_cmd(8'h12, 8'h00, 8'h00, 8'hff, 0, "R2");
    chk(illegal_o == 1'b0, "R2", illegal_o, 0);
    // good command after illegal clears flag
    run_cmd(8'h12, 8'h01, 8'h81, 8'hff, 0, "R10");
    bp_en = 1;
    run_cmd(8'h12, 8'h01, 8'h80, 8'hff, 8, "R7");
    chk(illegal_o == 1'b0, "R10", illegal_o, 0);

    repeat (3) @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule